// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the command and state controller for the digital section of a delta-sigma converter. It runs on the master clock. Two host pins, a convert strobe and a calibrate level, are resynchronised and decoded into commands. The sequencer then steps through a power-up wake-up wait, an idle standby, a two-phase self-calibration (offset first, gain second) and timed conversions. Each of these phases is timed in master-clock cycles by a single down-counter.

Only the control side is modelled. The modulator, filter arithmetic and calibration maths live elsewhere. For those blocks the sequencer provides its state code, a one-cycle conversion-done strobe at the data-ready point, and the polarity mode (unipolar or bipolar) to apply to the finished word. The polarity pin is never latched at conversion start. It is sampled a fixed number of cycles before data-ready. An internal half-rate phase adds up to one extra cycle when a command leaves standby.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After synchronous reset, `state_o` reads 0 (wake-up) for exactly 1800 master-clock cycles, counted from the first cycle with `rst_n` high. It then reads 1 (standby) if no command arrived.
- R2: A command issued during wake-up is held in a one-entry pending slot. It is executed on the clock edge that ends wake-up, so the state leaves 0 directly for the commanded state, 1800 cycles after reset release.
- R3: From standby, a rising edge on `conv_i` is a command. It starts calibration (`state_o` = 2) when `cal_i` is high and a conversion (`state_o` = 4) when `cal_i` is low. Call the first clock edge that samples `conv_i` high edge k. The new state shows after edge k+2 or edge k+3, because of input synchronisation and the half-rate phase.
- R4: Calibration spends 1623 cycles in offset phase (`state_o` = 2), then 1623 cycles in gain phase (`state_o` = 3), for a total of 3246 cycles.
- R5: When calibration ends, `conv_i` is sampled. If it is high, a conversion (`state_o` = 4) follows on the next cycle. If it is low, the state returns to standby (1).
- R6: During calibration, a `conv_i` rising edge with `cal_i` high restarts calibration at the offset phase, two edges after edge k. A `conv_i` rising edge with `cal_i` low has no effect on the calibration timing.
- R7: A conversion entered from standby or from calibration lasts 1624 cycles. `done_o` is high for exactly one cycle, the last cycle of the conversion.
- R8: If `conv_i` is high in the `done_o` cycle, the next conversion starts at once and lasts 1622 cycles, so `done_o` pulses repeat every 1622 cycles. If `conv_i` is low, the state returns to standby in the following cycle.
- R9: A `conv_i` rising edge with `cal_i` low during a conversion abandons it and starts a new 1624-cycle conversion two edges after edge k, so `done_o` appears 1624+2 edges after edge k−1.
- R10: `bip_mode_o` takes the synchronised `bip_i` level 82 cycles before the `done_o` cycle and holds it until the next conversion. A level change closer to `done_o` than that is not reported. `bip_mode_o` never changes outside a conversion, including during calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_i | input | 1 | Convert command pin, asynchronous, acts on its rising edge |
| cal_i | input | 1 | Calibrate qualifier level, asynchronous |
| bip_i | input | 1 | Polarity select level, 1 = bipolar, asynchronous |
| state_o | output | 3 | 0 wake-up, 1 standby, 2 offset calibration, 3 gain calibration, 4 converting |
| done_o | output | 1 | One-cycle conversion-done strobe at data-ready |
| bip_mode_o | output | 1 | Polarity mode belonging to the latest finished conversion |

## Verification
The hardest situations to reach are the mid-operation commands: a calibrate restart that arrives in the gain phase, a convert edge that must be ignored in the middle of calibration, and a command held across the wake-up boundary. The stimulus reaches each one by issuing a first command, counting master-clock cycles from the moment it was driven, and issuing the second command at a fixed cycle offset that falls inside the target phase. The same cycle counting places `bip_i` changes at 40 and 200 cycles before the predicted data-ready point. This separates sampling at the 82-cycle lead from sampling at conversion start.

// File: rtl/adc_seq_pkg.sv
// Shared types for the conversion sequencer.
// Assumes: state codes are visible at the top-level port and are fixed.
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_WAKE     = 3'd0,
        ST_IDLE     = 3'd1,
        ST_CAL_OFS  = 3'd2,
        ST_CAL_GAIN = 3'd3,
        ST_CONV     = 3'd4
    } seq_state_e;

endpackage

// File: rtl/adc_seq_sync.sv
// Two-flop level synchroniser, one independent chain per input bit.
// Assumes: inputs are asynchronous levels; outputs reset to 0.
module adc_seq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic sync_q;

        // Shift the raw pin through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= din[i];
                sync_q <= meta_q;
            end
        end

        assign lvl[i] = sync_q;
    end

endmodule

// File: rtl/adc_seq_timer.sv
// Loadable down-counter that stops at zero.
// Assumes: the loaded value is the phase length minus one, so a phase
// lasts value+1 cycles, including the cycle in which zero is flagged.
module adc_seq_timer #(
    parameter int CW      = 12,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          zero
);

    // Load on request, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= CW'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && zero) |=> zero); // R7

    AST_TMR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val))); // R4

endmodule

// File: rtl/adc_seq_polsel.sv
// Polarity-mode sampler. While a conversion runs, it captures the
// synchronised polarity level when the conversion counter equals LEAD.
// Assumes: the counter reaches 0 in the done cycle, and LEAD is shorter
// than every conversion length.
module adc_seq_polsel #(
    parameter int CW   = 12,
    parameter int LEAD = 82
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [CW-1:0] cnt,
    input  logic          bip_lvl,
    output logic          pol_o
);

    localparam logic [CW-1:0] LEAD_V = CW'(LEAD);

    // Take the polarity level once per conversion, at the lead point.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pol_o <= 1'b0;
        else if (active && (cnt == LEAD_V))
            pol_o <= bip_lvl;
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
// Conversion/calibration sequencer for a delta-sigma converter.
// It decodes a convert rising edge, qualified by the calibrate level, and
// sequences wake-up, standby, offset and gain calibration, and conversions.
// A single down-counter times every phase.
// Assumes: asynchronous pins, a synchronous active-low reset, and a
// free-running half-rate phase that only gates departures from standby.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int WAKE_CYCLES       = 1800,
    parameter int CAL_CYCLES        = 3246,
    parameter int CONV_FIRST_CYCLES = 1624,
    parameter int CONV_NEXT_CYCLES  = 1622,
    parameter int POL_LEAD_CYCLES   = 82
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       conv_i,
    input  logic       cal_i,
    input  logic       bip_i,
    output logic [2:0] state_o,
    output logic       done_o,
    output logic       bip_mode_o
);

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int CAL_OFS_LEN  = CAL_CYCLES / 2;
    localparam int CAL_GAIN_LEN = CAL_CYCLES - CAL_OFS_LEN;
    localparam int MAX_LEN      = max_of(max_of(WAKE_CYCLES, CAL_GAIN_LEN),
                                         max_of(CONV_FIRST_CYCLES, CONV_NEXT_CYCLES));
    localparam int CW           = $clog2(MAX_LEN + 1);

    localparam logic [CW-1:0] OFS_LD   = CW'(CAL_OFS_LEN - 1);
    localparam logic [CW-1:0] GAIN_LD  = CW'(CAL_GAIN_LEN - 1);
    localparam logic [CW-1:0] FIRST_LD = CW'(CONV_FIRST_CYCLES - 1);
    localparam logic [CW-1:0] NEXT_LD  = CW'(CONV_NEXT_CYCLES - 1);

    logic [2:0]    sync_lvl;
    logic          conv_lvl, cal_lvl, bip_lvl;
    logic          conv_prev, conv_rise;
    logic          tick;
    seq_state_e    state, nxt;
    logic          tmr_load;
    logic [CW-1:0] tmr_val, tmr_cnt;
    logic          tmr_zero;
    logic          pend_v, pend_cal;
    logic          take;
    logic          cmd_req, cmd_cal;
    seq_state_e    cmd_st;
    logic [CW-1:0] cmd_ld;

    adc_seq_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({bip_i, cal_i, conv_i}),
        .lvl   (sync_lvl)
    );

    assign conv_lvl = sync_lvl[0];
    assign cal_lvl  = sync_lvl[1];
    assign bip_lvl  = sync_lvl[2];

    // Remember the last synchronised convert level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) conv_prev <= 1'b0;
        else        conv_prev <= conv_lvl;
    end

    assign conv_rise = conv_lvl & ~conv_prev;

    // Internal half-rate phase; standby only acts when it is high.
    always_ff @(posedge clk) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= ~tick;
    end

    // A fresh edge wins over a held command and brings its own qualifier.
    assign cmd_req = conv_rise | pend_v;
    assign cmd_cal = conv_rise ? cal_lvl : pend_cal;
    assign cmd_st  = cmd_cal ? ST_CAL_OFS : ST_CONV;
    assign cmd_ld  = cmd_cal ? OFS_LD : FIRST_LD;

    adc_seq_timer #(.CW(CW), .RST_VAL(WAKE_CYCLES - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .zero     (tmr_zero)
    );

    // Next-state and timer-reload decision.
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = FIRST_LD;
        take     = 1'b0;
        unique case (state)
            ST_WAKE: begin
                if (tmr_zero) begin
                    if (cmd_req) begin
                        take     = 1'b1;
                        nxt      = cmd_st;
                        tmr_load = 1'b1;
                        tmr_val  = cmd_ld;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_IDLE: begin
                if (cmd_req && tick) begin
                    take     = 1'b1;
                    nxt      = cmd_st;
                    tmr_load = 1'b1;
                    tmr_val  = cmd_ld;
                end
            end
            ST_CAL_OFS: begin
                if (conv_rise && cal_lvl) begin
                    nxt      = ST_CAL_OFS;
                    tmr_load = 1'b1;
                    tmr_val  = OFS_LD;
                end else if (tmr_zero) begin
                    nxt      = ST_CAL_GAIN;
                    tmr_load = 1'b1;
                    tmr_val  = GAIN_LD;
                end
            end
            ST_CAL_GAIN: begin
                if (conv_rise && cal_lvl) begin
                    nxt      = ST_CAL_OFS;
                    tmr_load = 1'b1;
                    tmr_val  = OFS_LD;
                end else if (tmr_zero) begin
                    if (conv_lvl) begin
                        nxt      = ST_CONV;
                        tmr_load = 1'b1;
                        tmr_val  = FIRST_LD;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_CONV: begin
                if (conv_rise) begin
                    nxt      = cal_lvl ? ST_CAL_OFS : ST_CONV;
                    tmr_load = 1'b1;
                    tmr_val  = cal_lvl ? OFS_LD : FIRST_LD;
                end else if (tmr_zero) begin
                    if (conv_lvl) begin
                        nxt      = ST_CONV;
                        tmr_load = 1'b1;
                        tmr_val  = NEXT_LD;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAKE;
        else        state <= nxt;
    end

    // One-entry pending command slot, live only in wake-up and standby.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v   <= 1'b0;
            pend_cal <= 1'b0;
        end else if (state == ST_WAKE || state == ST_IDLE) begin
            if (take) begin
                pend_v <= 1'b0;
            end else if (conv_rise) begin
                pend_v   <= 1'b1;
                pend_cal <= cal_lvl;
            end
        end else begin
            pend_v <= 1'b0;
        end
    end

    adc_seq_polsel #(.CW(CW), .LEAD(POL_LEAD_CYCLES)) u_pol (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state == ST_CONV),
        .cnt     (tmr_cnt),
        .bip_lvl (bip_lvl),
        .pol_o   (bip_mode_o)
    );

    assign state_o = state;
    assign done_o  = (state == ST_CONV) && tmr_zero;

    AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE && !tmr_zero) |=> (state == ST_WAKE)); // R1

    AST_GAIN_AFTER_OFS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAL_GAIN && $past(state) != ST_CAL_GAIN) |-> ($past(state) == ST_CAL_OFS)); // R4

    AST_CAL_IGNORES_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CAL_OFS || state == ST_CAL_GAIN) && conv_rise && !cal_lvl && !tmr_zero)
        |=> (state == $past(state))); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_CONV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && conv_rise && !cal_lvl) |=> (state == ST_CONV && tmr_cnt == FIRST_LD)); // R9

    AST_POL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_CONV) |=> $stable(bip_mode_o)); // R10

endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
// Scoreboard bench: driver tasks queue expected events (state changes and
// done strobes with timing windows); a monitor pops and compares them.
module adc_seq_ctrl_tb_top;

    localparam int W  = 1800;
    localparam int PH = 1623;
    localparam int F  = 1624;
    localparam int N  = 1622;
    localparam int EV_DONE = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_i = 1'b0;
    logic       cal_i = 1'b0;
    logic       bip_i = 1'b0;
    logic [2:0] state_o;
    logic       done_o;
    logic       bip_mode_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int last_ev = 0;
    logic [2:0] prev_st = 3'd0;

    typedef struct {
        int    code;
        bit    rel;
        int    lo;
        int    hi;
        int    pol;
        string tag;
    } exp_t;

    exp_t q[$];

    adc_seq_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_i     (conv_i),
        .cal_i      (cal_i),
        .bip_i      (bip_i),
        .state_o    (state_o),
        .done_o     (done_o),
        .bip_mode_o (bip_mode_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic push(input int code, input bit rel, input int lo, input int hi,
                        input int pol, input string tag);
        exp_t e;
        e.code = code; e.rel = rel; e.lo = lo; e.hi = hi; e.pol = pol; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic handle(input int code);
        exp_t e;
        int   dt;
        if (q.size() == 0) begin
            check(1'b0, (code == EV_DONE) ? "R8" : "R3", "unexpected event", code, -1);
        end else begin
            e = q.pop_front();
            check(code == e.code, e.tag, "event code", code, e.code);
            dt = e.rel ? (cyc - last_ev) : cyc;
            check(dt >= e.lo && dt <= e.hi, e.tag, "event cycle", dt, e.lo);
            if (e.pol >= 0)
                check(int'(bip_mode_o) == e.pol, e.tag, "polarity", int'(bip_mode_o), e.pol);
        end
        last_ev = cyc;
    endtask

    // Monitor: sample away from the edge, turn output changes into events.
    always @(posedge clk) begin
        #2;
        if (!rst_n) begin
            last_ev = cyc;
            prev_st = state_o;
        end else begin
            if (state_o != prev_st) handle(int'(state_o));
            prev_st = state_o;
            if (done_o) handle(EV_DONE);
        end
    end

    task automatic at_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic fire(input bit cal_lvl, output int n0);
        @(negedge clk);
        cal_i  = cal_lvl;
        conv_i = 1'b1;
        n0     = cyc;
    endtask

    task automatic release_cmd(input int hold);
        repeat (hold) @(negedge clk);
        conv_i = 1'b0;
        cal_i  = 1'b0;
    endtask

    task automatic drain(input string tag);
        int guard = 0;
        while (q.size() != 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(q.size() == 0, tag, "missing events", q.size(), 0);
        q.delete();
        repeat (20) @(negedge clk);
    endtask

    task automatic do_reset(output int m);
        @(negedge clk);
        rst_n  = 1'b0;
        conv_i = 1'b0;
        cal_i  = 1'b0;
        repeat (4) @(negedge clk);
        check(state_o == 3'd0, "R1", "reset state", int'(state_o), 0);
        check(done_o == 1'b0, "R7", "reset done", int'(done_o), 0);
        check(bip_mode_o == 1'b0, "R10", "reset polarity", int'(bip_mode_o), 0);
        rst_n = 1'b1;
        m = cyc;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : driver
        int m, n0, n1;

        // R1: wake-up then standby with no command
        repeat (2) @(negedge clk);
        do_reset(m);
        push(1, 1'b1, W, W, -1, "R1");
        drain("R1");

        // R3, R4, R5: calibration from standby, convert low at the end
        fire(1'b1, n0);
        push(2, 1'b0, n0 + 3, n0 + 4, -1, "R3");
        push(3, 1'b1, PH, PH, -1, "R4");
        push(1, 1'b1, PH, PH, -1, "R5");
        release_cmd(10);
        drain("R4");

        // R5, R7, R8: calibration then conversions while convert stays high
        fire(1'b1, n0);
        push(2, 1'b0, n0 + 3, n0 + 4, -1, "R3");
        push(3, 1'b1, PH, PH, -1, "R4");
        push(4, 1'b1, PH, PH, -1, "R5");
        push(EV_DONE, 1'b1, F - 1, F - 1, 0, "R7");
        push(EV_DONE, 1'b1, N, N, 0, "R8");
        push(1, 1'b1, 1, 1, -1, "R8");
        repeat (10) @(negedge clk);
        cal_i = 1'b0;
        while (q.size() > 2) @(negedge clk);
        repeat (100) @(negedge clk);
        conv_i = 1'b0;
        drain("R8");

        // R3, R10: polarity change 40 cycles before data-ready is not seen
        bip_i = 1'b1;
        repeat (20) @(negedge clk);
        fire(1'b0, n0);
        push(4, 1'b0, n0 + 3, n0 + 4, -1, "R3");
        push(EV_DONE, 1'b1, F - 1, F - 1, 1, "R10");
        push(1, 1'b1, 1, 1, -1, "R8");
        release_cmd(10);
        at_cyc(n0 + F - 38);
        bip_i = 1'b0;
        drain("R10");

        // R10: polarity change 200 cycles before data-ready is seen
        bip_i = 1'b1;
        repeat (20) @(negedge clk);
        fire(1'b0, n0);
        push(4, 1'b0, n0 + 3, n0 + 4, -1, "R3");
        push(EV_DONE, 1'b1, F - 1, F - 1, 0, "R10");
        push(1, 1'b1, 1, 1, -1, "R8");
        release_cmd(10);
        at_cyc(n0 + F - 200);
        bip_i = 1'b0;
        drain("R10");

        // R9: new convert edge mid-conversion restarts it
        fire(1'b0, n0);
        push(4, 1'b0, n0 + 3, n0 + 4, -1, "R3");
        release_cmd(10);
        at_cyc(n0 + 500);
        fire(1'b0, n1);
        push(EV_DONE, 1'b0, n1 + F + 2, n1 + F + 2, 0, "R9");
        push(1, 1'b1, 1, 1, -1, "R8");
        release_cmd(10);
        drain("R9");

        // R6: calibrate edge in gain phase restarts calibration
        fire(1'b1, n0);
        push(2, 1'b0, n0 + 3, n0 + 4, -1, "R3");
        push(3, 1'b1, PH, PH, -1, "R4");
        release_cmd(10);
        drain("R6");
        at_cyc(n0 + 2000);
        fire(1'b1, n1);
        push(2, 1'b0, n1 + 3, n1 + 3, -1, "R6");
        push(3, 1'b1, PH, PH, -1, "R6");
        push(1, 1'b1, PH, PH, -1, "R5");
        release_cmd(10);
        drain("R6");

        // R6, R10: convert edge with calibrate low and polarity change ignored
        fire(1'b1, n0);
        push(2, 1'b0, n0 + 3, n0 + 4, -1, "R3");
        push(3, 1'b1, PH, PH, -1, "R6");
        push(1, 1'b1, PH, PH, -1, "R6");
        release_cmd(10);
        at_cyc(n0 + 500);
        fire(1'b0, n1);
        release_cmd(10);
        at_cyc(n0 + 600);
        bip_i = 1'b1;
        drain("R6");
        check(bip_mode_o == 1'b0, "R10", "polarity after calibration", int'(bip_mode_o), 0);
        bip_i = 1'b0;

        // R2: command during wake-up runs exactly when wake-up ends
        do_reset(m);
        push(2, 1'b1, W, W, -1, "R2");
        push(3, 1'b1, PH, PH, -1, "R4");
        push(1, 1'b1, PH, PH, -1, "R5");
        at_cyc(m + 500);
        fire(1'b1, n0);
        release_cmd(10);
        drain("R2");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule